// File: doc/BRIEF.md
# Flash Programming Mode Gate

This block controls a dedicated programming mode. In this mode a serial slave port gets direct erase, read and write access to an on-chip flash array, and the processor is halted. The mode can start only after the SPI side asks for it and every protection input agrees. Once the mode is on, it holds until reset. No command, byte or input change can turn it off.

Inside the mode the block turns byte-level SPI traffic into flash operations. Reads return one byte per request, and the address steps by one each time. Write bytes are paired into 16-bit words that start at an even address, and each word goes to the flash only when its second byte arrives. A two-bit bank register, loaded by single-byte SPI transactions, supplies the top address bits so that all 128 KB can be reached through a 32 KB window. A secure input limits the mode to mass erase. A ready-error flag reports any command or word that was refused.

Top module: `sfm_ctrl`

## Requirements
- R1: `cpuHalt` rises one cycle after an `invokeReq` pulse only if, in that cycle, all four conditions hold: `debugEn`=1, `preboot`=0, `supplyOk`=1 and `unlockKey`=4'b0010. If any one of them fails, the mode does not start.
- R2: An `invokeReq` with `invokeFromCpu`=1 (a write from the processor bus) has no effect, and the mode stays off.
- R3: Once the mode is on, `cpuHalt` stays 1 until `rstN` is low, whatever the other inputs do. While it is 1, `spiIrqOut` is 0. While it is 0, `spiIrqOut` follows `spiIrqIn`.
- R4: With `secureBit`=1, read commands (`cmdOp`=2'b01) and write commands (`cmdOp`=2'b10) are refused: `readyErr` is set and `flashRd`/`flashWr` never pulse. A mass erase command (`cmdOp`=2'b11) is still accepted and pulses `flashErase` one cycle later.
- R5: A write command whose `cmdAddr` bit 0 is 1 sets `readyErr`, and the bytes that follow produce no `flashWr`.
- R6: In a write burst, the first byte of each pair is stored as the low half and the second byte as the high half. One cycle after the second byte, `flashWr` pulses once with `flashWrData`={second,first} and `flashWrAddr`={bank, byte address bits 14:1}.
- R7: `flashReady` falls in the cycle `flashWr` or `flashErase` pulses and rises the cycle after a `flashDone` pulse. A word completed while it is low is dropped: no `flashWr`, `readyErr` is set, and the address still advances by two.
- R8: In a read burst, each `rdByteReq` raises `flashRd` in that same cycle. `flashAddr` is {bank, pointer}, and `rdData` equals `flashRdData`. The pointer starts at `cmdAddr` and goes up by one per request.
- R9: `bankWr` loads `bankData` into the top two flash address bits only while the mode is on. Outside the mode it is ignored.
- R10: Any command outside the mode sets `readyErr`. A command that is accepted clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (pin or watchdog); the only way out of the mode |
| invokeReq | input | 1 | Pulse: mode-invoke registers written |
| invokeFromCpu | input | 1 | 1 when that write came from the processor bus |
| debugEn | input | 1 | Debug enable condition |
| preboot | input | 1 | Preboot flag; must be 0 |
| supplyOk | input | 1 | External supply above threshold |
| secureBit | input | 1 | Secure mode; limits the mode to mass erase |
| unlockKey | input | 4 | Unlock field; must be 4'b0010 |
| cmdValid | input | 1 | Pulse: a new command has been decoded |
| cmdOp | input | 2 | 01 read, 10 write, 11 mass erase |
| cmdAddr | input | 15 | Start byte address inside the bank window |
| wrByteValid | input | 1 | Pulse: a write data byte is available |
| wrByte | input | 8 | Write data byte |
| rdByteReq | input | 1 | Request for the next read byte |
| rdData | output | 8 | Read byte returned to the SPI side |
| bankWr | input | 1 | Pulse: single-byte transaction seen |
| bankData | input | 2 | Low two command bits of that transaction |
| spiIrqIn | input | 1 | SPI interrupt request |
| spiIrqOut | output | 1 | Gated SPI interrupt to the processor |
| cpuHalt | output | 1 | Processor halt, 1 while the mode is on |
| flashAddr | output | 17 | Flash byte address for reads |
| flashRd | output | 1 | Flash read strobe |
| flashRdData | input | 8 | Flash read data |
| flashWr | output | 1 | Flash word write strobe |
| flashWrAddr | output | 16 | Flash word address |
| flashWrData | output | 16 | Flash word data |
| flashErase | output | 1 | Mass erase strobe |
| flashDone | input | 1 | Pulse: flash write or erase finished |
| flashReady | output | 1 | Mode on and no flash operation pending |
| readyErr | output | 1 | Last command or word was refused |

## Verification
The checker watches several rules on every cycle:
- the halt stays on once it is set;
- the interrupt stays gated while halted;
- every read or write strobe occurs in the mode with security off;
- every write or erase strobe coincides with the ready line low;
- the bank address bits change only in the mode.

Other behaviour needs a prepared sequence of inputs, so only the bench's scenarios can show it:
- the single-condition entry refusals and the processor-side invoke;
- the byte order inside a word;
- odd-start rejection;
- dropping a word while the flash is busy, with the address still advancing;
- the read address stepping;
- error clearing.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_ERASE = 2'b11
  } sfmOpE;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } sfmStE;

  typedef struct packed {
    logic loadPtr;
    logic incByte;
    logic incWord;
    logic storeLow;
    logic commit;
    logic loadBank;
  } sfmStrobeT;

  localparam logic [3:0] UNLOCK_CODE = 4'b0010;
endpackage

// File: rtl/sfm_ctrl_fsm.sv
module sfm_ctrl_fsm
  import sfm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            invokeReq,
  input  logic            invokeFromCpu,
  input  logic            debugEn,
  input  logic            preboot,
  input  logic            supplyOk,
  input  logic            secureBit,
  input  logic [3:0]      unlockKey,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic            cmdAddrLsb,
  input  logic            wrByteValid,
  input  logic            rdByteReq,
  input  logic            bankWr,
  input  logic            flashDone,
  output logic            modeOn,
  output logic            flashReady,
  output logic            readyErr,
  output logic            flashRd,
  output logic            flashWr,
  output logic            flashErase,
  output sfmStrobeT       stb
);
  sfmStE st, stNext;
  logic  phase, phaseNext;
  logic  pending, pendSet;
  logic  errSet, errClr;
  logic  commitNext, eraseNext;
  logic  entryOk;

  assign entryOk = invokeReq && !invokeFromCpu && debugEn && !preboot &&
                   supplyOk && (unlockKey == UNLOCK_CODE);

  always_comb begin
    stb        = '0;
    stNext     = st;
    phaseNext  = phase;
    errSet     = 1'b0;
    errClr     = 1'b0;
    commitNext = 1'b0;
    eraseNext  = 1'b0;
    pendSet    = 1'b0;
    flashRd    = modeOn && (st == ST_READ) && rdByteReq;
    if (flashRd) stb.incByte = 1'b1;
    if (bankWr && modeOn) stb.loadBank = 1'b1;
    if (cmdValid) begin
      errClr    = 1'b1;
      stNext    = ST_IDLE;
      phaseNext = 1'b0;
      if (!modeOn) begin
        errSet = 1'b1;
      end else begin
        case (sfmOpE'(cmdOp))
          OP_READ: begin
            if (secureBit) errSet = 1'b1;
            else begin stNext = ST_READ; stb.loadPtr = 1'b1; end
          end
          OP_WRITE: begin
            if (secureBit || cmdAddrLsb) errSet = 1'b1;
            else begin stNext = ST_WRITE; stb.loadPtr = 1'b1; end
          end
          OP_ERASE: begin
            if (pending) errSet = 1'b1;
            else begin eraseNext = 1'b1; pendSet = 1'b1; end
          end
          default: ;
        endcase
      end
    end else if (wrByteValid && modeOn && (st == ST_WRITE)) begin
      if (!phase) begin
        stb.storeLow = 1'b1;
        phaseNext    = 1'b1;
      end else begin
        phaseNext   = 1'b0;
        stb.incWord = 1'b1;
        if (pending) errSet = 1'b1;
        else begin stb.commit = 1'b1; commitNext = 1'b1; pendSet = 1'b1; end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeOn     <= 1'b0;
      st         <= ST_IDLE;
      phase      <= 1'b0;
      pending    <= 1'b0;
      readyErr   <= 1'b0;
      flashWr    <= 1'b0;
      flashErase <= 1'b0;
    end else begin
      if (entryOk) modeOn <= 1'b1;
      st         <= stNext;
      phase      <= phaseNext;
      flashWr    <= commitNext;
      flashErase <= eraseNext;
      if (pendSet)        pending <= 1'b1;
      else if (flashDone) pending <= 1'b0;
      if (errSet)      readyErr <= 1'b1;
      else if (errClr) readyErr <= 1'b0;
    end
  end

  assign flashReady = modeOn && !pending;
endmodule

// File: rtl/sfm_datapath.sv
module sfm_datapath
  import sfm_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int WIN_W  = 15,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sfmStrobeT                  stb,
  input  logic [WIN_W-1:0]           cmdAddr,
  input  logic [BYTE_W-1:0]          wrByte,
  input  logic [BANK_W-1:0]          bankData,
  output logic [BANK_W+WIN_W-1:0]    flashAddr,
  output logic [BANK_W+WIN_W-2:0]    flashWrAddr,
  output logic [2*BYTE_W-1:0]        flashWrData
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WIN_W-1:0]  ptr;
  logic [BYTE_W-1:0] lowByte;
  logic [BANK_W-1:0] bank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr         <= '0;
      lowByte     <= '0;
      bank        <= '0;
      flashWrAddr <= '0;
      flashWrData <= '0;
    end else begin
      if (stb.loadPtr)      ptr <= cmdAddr;
      else if (stb.incWord) ptr <= ptr + WIN_W'(2);
      else if (stb.incByte) ptr <= ptr + WIN_W'(1);
      if (stb.storeLow) lowByte <= wrByte;
      if (stb.loadBank) bank <= bankData;
      if (stb.commit) begin
        flashWrData <= WORD_W'({wrByte, lowByte});
        flashWrAddr <= {bank, ptr[WIN_W-1:1]};
      end
    end
  end

  assign flashAddr = {bank, ptr};
endmodule

// File: rtl/sfm_ctrl.sv
module sfm_ctrl
  import sfm_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int WIN_W  = 15,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    invokeReq,
  input  logic                    invokeFromCpu,
  input  logic                    debugEn,
  input  logic                    preboot,
  input  logic                    supplyOk,
  input  logic                    secureBit,
  input  logic [3:0]              unlockKey,
  input  logic                    cmdValid,
  input  logic [1:0]              cmdOp,
  input  logic [WIN_W-1:0]        cmdAddr,
  input  logic                    wrByteValid,
  input  logic [BYTE_W-1:0]       wrByte,
  input  logic                    rdByteReq,
  output logic [BYTE_W-1:0]       rdData,
  input  logic                    bankWr,
  input  logic [BANK_W-1:0]       bankData,
  input  logic                    spiIrqIn,
  output logic                    spiIrqOut,
  output logic                    cpuHalt,
  output logic [BANK_W+WIN_W-1:0] flashAddr,
  output logic                    flashRd,
  input  logic [BYTE_W-1:0]       flashRdData,
  output logic                    flashWr,
  output logic [BANK_W+WIN_W-2:0] flashWrAddr,
  output logic [2*BYTE_W-1:0]     flashWrData,
  output logic                    flashErase,
  input  logic                    flashDone,
  output logic                    flashReady,
  output logic                    readyErr
);
  sfmStrobeT stb;
  logic      modeOn;

  sfm_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .invokeReq(invokeReq), .invokeFromCpu(invokeFromCpu),
    .debugEn(debugEn), .preboot(preboot), .supplyOk(supplyOk), .secureBit(secureBit),
    .unlockKey(unlockKey), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddrLsb(cmdAddr[0]),
    .wrByteValid(wrByteValid), .rdByteReq(rdByteReq), .bankWr(bankWr),
    .flashDone(flashDone), .modeOn(modeOn), .flashReady(flashReady),
    .readyErr(readyErr), .flashRd(flashRd), .flashWr(flashWr),
    .flashErase(flashErase), .stb(stb)
  );

  sfm_datapath #(.BANK_W(BANK_W), .WIN_W(WIN_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr), .wrByte(wrByte),
    .bankData(bankData), .flashAddr(flashAddr), .flashWrAddr(flashWrAddr),
    .flashWrData(flashWrData)
  );

  assign cpuHalt   = modeOn;
  assign spiIrqOut = spiIrqIn && !modeOn;
  assign rdData    = flashRdData;
endmodule

// File: rtl/sfm_ctrl_chk.sv
module sfm_ctrl_chk #(
  parameter int BANK_W = 2,
  parameter int WIN_W  = 15
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cpuHalt,
  input logic                    spiIrqOut,
  input logic                    secureBit,
  input logic                    flashRd,
  input logic                    flashWr,
  input logic                    flashErase,
  input logic                    flashReady,
  input logic [BANK_W+WIN_W-1:0] flashAddr
);
  // R3
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |=> cpuHalt);

  // R3
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |-> !spiIrqOut);

  // R4
  rd_secure_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashRd |-> (cpuHalt && !secureBit));

  // R4
  wr_secure_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashWr |-> (cpuHalt && !secureBit));

  // R7
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flashWr || flashErase) |-> !flashReady);

  // R9
  bank_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuHalt |=> $stable(flashAddr[BANK_W+WIN_W-1:WIN_W]));
endmodule

bind sfm_ctrl sfm_ctrl_chk #(.BANK_W(BANK_W), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuHalt(cpuHalt), .spiIrqOut(spiIrqOut),
  .secureBit(secureBit), .flashRd(flashRd), .flashWr(flashWr),
  .flashErase(flashErase), .flashReady(flashReady), .flashAddr(flashAddr)
);

// File: tb/sim_sfm_ctrl.sv
module sim_sfm_ctrl;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        invokeReq = 0, invokeFromCpu = 0, debugEn = 0, preboot = 1;
  logic        supplyOk = 0, secureBit = 0;
  logic [3:0]  unlockKey = 4'h0;
  logic        cmdValid = 0;
  logic [1:0]  cmdOp = 2'b00;
  logic [14:0] cmdAddr = '0;
  logic        wrByteValid = 0;
  logic [7:0]  wrByte = '0;
  logic        rdByteReq = 0;
  logic [7:0]  rdData;
  logic        bankWr = 0;
  logic [1:0]  bankData = '0;
  logic        spiIrqIn = 0, spiIrqOut, cpuHalt;
  logic [16:0] flashAddr;
  logic        flashRd;
  logic [7:0]  flashRdData;
  logic        flashWr;
  logic [15:0] flashWrAddr, flashWrData;
  logic        flashErase, flashDone = 0, flashReady, readyErr;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign flashRdData = flashAddr[7:0] ^ 8'h5A;

  sfm_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    rstN = 0; invokeReq = 0; cmdValid = 0; wrByteValid = 0; rdByteReq = 0;
    bankWr = 0; flashDone = 0; secureBit = 0;
    tick(); tick(); rstN = 1; tick();
  endtask

  task automatic setGood();
    debugEn = 1; preboot = 0; supplyOk = 1; unlockKey = 4'b0010; invokeFromCpu = 0;
  endtask

  task automatic pulseInvoke();
    invokeReq = 1; tick(); invokeReq = 0;
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic [14:0] a);
    cmdOp = op; cmdAddr = a; cmdValid = 1; tick(); cmdValid = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    wrByte = b; wrByteValid = 1; tick(); wrByteValid = 0;
  endtask

  task automatic testReset();
    doReset();
    chk("R3 reset halt", cpuHalt, 0);
    chk("R7 reset ready", flashReady, 0);
    chk("R10 reset err", readyErr, 0);
    chk("R6 reset wr", flashWr, 0);
  endtask

  task automatic testEntry();
    for (int k = 0; k < 5; k++) begin
      doReset(); setGood();
      case (k)
        0: debugEn = 0;
        1: preboot = 1;
        2: supplyOk = 0;
        3: unlockKey = 4'b0011;
        default: invokeFromCpu = 1;
      endcase
      pulseInvoke();
      if (k == 4) chk("R2 cpu invoke ignored", cpuHalt, 0);
      else chk("R1 entry blocked", cpuHalt, 0);
    end
    doReset(); setGood();
    spiIrqIn = 1; #1;
    chk("R3 irq passes when off", spiIrqOut, 1);
    pulseInvoke();
    chk("R1 entry ok", cpuHalt, 1);
    chk("R3 irq gated", spiIrqOut, 0);
    chk("R7 ready after entry", flashReady, 1);
    debugEn = 0; supplyOk = 0; preboot = 1;
    sendCmd(2'b00, 0); tick(); tick();
    chk("R3 sticky", cpuHalt, 1);
    spiIrqIn = 0;
  endtask

  task automatic testOutsideMode();
    doReset(); bankWr = 1; bankData = 2'b11; tick(); bankWr = 0;
    sendCmd(2'b01, 15'h0000);
    chk("R10 cmd outside mode", readyErr, 1);
    setGood(); pulseInvoke();
    sendCmd(2'b01, 15'h0000);
    chk("R10 err cleared", readyErr, 0);
    rdByteReq = 1; #1;
    chk("R9 bank ignored outside mode", flashAddr, 17'h00000);
    tick(); rdByteReq = 0;
  endtask

  task automatic testWrite();
    doReset(); setGood(); pulseInvoke();
    sendCmd(2'b10, 15'h0010);
    sendByte(8'h34);
    chk("R6 no commit after first byte", flashWr, 0);
    sendByte(8'h12);
    chk("R6 commit", flashWr, 1);
    chk("R6 word data", flashWrData, 16'h1234);
    chk("R6 word addr", flashWrAddr, 16'h0008);
    chk("R7 ready low", flashReady, 0);
    tick();
    chk("R6 single pulse", flashWr, 0);
    sendByte(8'h78); sendByte(8'h56);
    chk("R7 refused word", flashWr, 0);
    chk("R7 refused err", readyErr, 1);
    flashDone = 1; tick(); flashDone = 0;
    chk("R7 ready back", flashReady, 1);
    sendByte(8'hBC); sendByte(8'h9A);
    chk("R7 commit after done", flashWr, 1);
    chk("R7 data", flashWrData, 16'h9ABC);
    chk("R7 addr advanced", flashWrAddr, 16'h000A);
    flashDone = 1; tick(); flashDone = 0;
    sendCmd(2'b10, 15'h0021);
    chk("R5 odd start err", readyErr, 1);
    sendByte(8'h11); sendByte(8'h22);
    chk("R5 no write", flashWr, 0);
  endtask

  task automatic testRead();
    doReset(); setGood(); pulseInvoke();
    bankData = 2'b11; bankWr = 1; tick(); bankWr = 0;
    sendCmd(2'b01, 15'h0100);
    for (int i = 0; i < 3; i++) begin
      rdByteReq = 1; #1;
      chk("R8 rd strobe", flashRd, 1);
      chk("R9 R8 addr", flashAddr, 17'h18100 + 17'(i));
      chk("R8 data", rdData, 8'(17'h18100 + 17'(i)) ^ 8'h5A);
      tick();
    end
    rdByteReq = 0;
  endtask

  task automatic testSecure();
    doReset(); setGood(); secureBit = 1; pulseInvoke();
    sendCmd(2'b01, 15'h0000);
    chk("R4 read refused", readyErr, 1);
    rdByteReq = 1; #1;
    chk("R4 no read strobe", flashRd, 0);
    tick(); rdByteReq = 0;
    sendCmd(2'b10, 15'h0000);
    chk("R4 write refused", readyErr, 1);
    sendByte(8'h01); sendByte(8'h02);
    chk("R4 no write", flashWr, 0);
    sendCmd(2'b11, 15'h0000);
    chk("R4 erase accepted", readyErr, 0);
    chk("R4 erase strobe", flashErase, 1);
    chk("R7 busy on erase", flashReady, 0);
  endtask

  initial begin
    testReset();
    testEntry();
    testOutsideMode();
    testWrite();
    testRead();
    testSecure();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule